// File: doc/BRIEF.md
# Swizzled Tile Address Sequencer

This block walks a two-dimensional tile of 32-bit elements and produces one on-chip scratchpad word address per cycle. It is meant for the engine that moves tile data into or out of a banked scratchpad. A start pulse latches the tile shape, the walk order and the placement mode. The block then presents the address of each element in turn, as a valid/ready stream.

There are four placement modes. The linear mode packs rows back to back. The padded mode leaves one spare word after every row, so the row pitch becomes odd. The plain XOR mode folds the row index into the column index. The swizzle mode flips a small field of the word address using higher address bits. The flip width depends on the selected access atom, and the base and shift of the field are parameters. The padded, plain XOR and swizzle modes exist so that a column walk over a tile whose width is a power of two spreads across banks (bank = word address mod 32) instead of landing in a single bank.

Top module: `tile_addr_seq`

## Requirements
- R1: While reset is high and after it falls with no start, `addr_valid` and `done` are 0.
- R2: A `start` seen while idle makes `addr_valid` 1 in the next cycle, carrying the address of element (row 0, col 0).
- R3: With `order_sel` = 0 (row-major) the column advances first and wraps to column 0 of the next row.
- R4: With `order_sel` = 1 (column-major) the row advances first and wraps to row 0 of the next column.
- R5: The walk advances only on a cycle with `addr_valid` and `ready` both 1. While `ready` is 0, the address is held.
- R6: `done` is 1 exactly while the last element's address is presented. After that address is accepted, `addr_valid` is 0 in the next cycle.
- R7: A `start` while busy is ignored, and the walk continues with the configuration latched at the first start.
- R8: `layout_sel` = 0 (linear) maps (r, c) to r·W + c.
- R9: `layout_sel` = 1 (padded) maps (r, c) to r·(W+1) + c.
- R10: `layout_sel` = 2 (plain XOR) maps (r, c) to r·W + (c XOR (r mod W)).
- R11: `layout_sel` = 3 (swizzle) takes a = r·W + c and emits a XOR (((a >> 5) AND (2^B − 1)) << 2). Here B equals `atom_sel` (0 none, 1 for 32-byte, 2 for 64-byte, 3 for 128-byte atoms).
- R12: W = 2^`width_log2` and H = 2^`height_log2`. Codes run from 0 to 6, and code 7 acts as 6. Exactly W·H addresses are emitted per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| width_log2 | input | 3 | log2 of tile width |
| height_log2 | input | 3 | log2 of tile height |
| order_sel | input | 1 | 0 row-major, 1 column-major |
| layout_sel | input | 2 | 0 linear, 1 padded, 2 plain XOR, 3 swizzle |
| atom_sel | input | 2 | Swizzle field width B |
| ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is presented |
| addr | output | 13 | Physical word address |
| done | output | 1 | Current address is the last of the tile |

## Verification
The first address is due one cycle after the edge that samples `start`. Each later address is due one cycle after the edge where it was accepted. `done` rises together with the last address, and `addr_valid` falls one cycle after the last acceptance. The bench drives inputs and samples outputs on the falling edge. It advances its expected element index only on falling-edge cycles where it set `ready` and saw `addr_valid`, so every comparison lands on the cycle in which the registered state reflects the previous acceptance. Stalls, a mid-walk start with changed settings, and a clamped dimension code are mixed into the random tiles.

// File: rtl/tas_pkg.sv
package tas_pkg;

    typedef enum logic {
        ORD_ROW = 1'b0,
        ORD_COL = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        LAY_LINEAR  = 2'd0,
        LAY_PADDED  = 2'd1,
        LAY_XOR     = 2'd2,
        LAY_SWIZZLE = 2'd3
    } layout_e;

    localparam int DIM_W = 3;

    typedef struct packed {
        logic [DIM_W-1:0] wlog;
        logic [DIM_W-1:0] hlog;
        order_e           order;
        layout_e          layout;
        logic [1:0]       atom;
    } tile_cfg_t;

    function automatic logic [DIM_W-1:0] clamp_log(input logic [DIM_W-1:0] v,
                                                   input int unsigned      maxv);
        return (32'(v) > maxv) ? DIM_W'(maxv) : v;
    endfunction

endpackage

// File: rtl/tas_walker.sv
module tas_walker
    import tas_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    localparam int IDX_W   = MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ready,
    input  tile_cfg_t        cfg_in,
    output logic             busy,
    output tile_cfg_t        cfg_q,
    output logic [IDX_W-1:0] row,
    output logic [IDX_W-1:0] col,
    output logic             last
);

    logic [IDX_W-1:0] wmax, hmax;
    logic             col_end, row_end;

    assign wmax    = IDX_W'((32'd1 << cfg_q.wlog) - 32'd1);
    assign hmax    = IDX_W'((32'd1 << cfg_q.hlog) - 32'd1);
    assign col_end = (col == wmax);
    assign row_end = (row == hmax);
    assign last    = col_end && row_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            row   <= '0;
            col   <= '0;
            cfg_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy       <= 1'b1;
                row        <= '0;
                col        <= '0;
                cfg_q      <= cfg_in;
                cfg_q.wlog <= clamp_log(cfg_in.wlog, MAX_LOG2);
                cfg_q.hlog <= clamp_log(cfg_in.hlog, MAX_LOG2);
            end
        end else if (ready) begin
            if (last) begin
                busy <= 1'b0;
            end else if (cfg_q.order == ORD_ROW) begin
                if (col_end) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end else begin
                if (row_end) begin
                    row <= '0;
                    col <= col + 1'b1;
                end else begin
                    row <= row + 1'b1;
                end
            end
        end
    end

    // R5: a stalled element stays put
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy && !ready |=> busy && $stable(row) && $stable(col));

    // R7: configuration is frozen while a walk runs
    p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(cfg_q));

    // R12: indices stay inside the tile
    p_bound_r12: assert property (@(posedge clk) disable iff (rst)
        busy |-> (row <= hmax) && (col <= wmax));

endmodule

// File: rtl/tas_mapper.sv
module tas_mapper
    import tas_pkg::*;
#(
    parameter int MAX_LOG2  = 6,
    parameter int SWZ_BASE  = 2,
    parameter int SWZ_SHIFT = 3,
    localparam int IDX_W    = MAX_LOG2,
    localparam int ADDR_W   = $clog2((1 << MAX_LOG2) * ((1 << MAX_LOG2) + 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  tile_cfg_t         cfg,
    input  logic [IDX_W-1:0]  row,
    input  logic [IDX_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] row_base, linear, swz_field, swz_mask;
    logic [IDX_W-1:0]  wmask, xcol;
    logic [ADDR_W:0]   tile_words;

    always_comb begin
        wmask     = IDX_W'((32'd1 << cfg.wlog) - 32'd1);
        xcol      = col ^ (row & wmask);
        row_base  = ADDR_W'(row) << cfg.wlog;
        linear    = row_base + ADDR_W'(col);
        swz_mask  = ADDR_W'((32'd1 << cfg.atom) - 32'd1);
        swz_field = ((linear >> (SWZ_BASE + SWZ_SHIFT)) & swz_mask) << SWZ_BASE;
        unique case (cfg.layout)
            LAY_LINEAR:  addr = linear;
            LAY_PADDED:  addr = row_base + ADDR_W'(row) + ADDR_W'(col);
            LAY_XOR:     addr = row_base + ADDR_W'(xcol);
            LAY_SWIZZLE: addr = linear ^ swz_field;
            default:     addr = linear;
        endcase
        tile_words = (ADDR_W+1)'(1) << ({1'b0, cfg.wlog} + {1'b0, cfg.hlog});
    end

    // R10, R11: permuting layouts never leave the tile footprint
    p_in_tile_r11: assert property (@(posedge clk) disable iff (rst)
        en && (cfg.layout != LAY_PADDED) |-> ({1'b0, addr} < tile_words));

    // R9: padded rows stay inside the padded footprint
    p_pad_fit_r9: assert property (@(posedge clk) disable iff (rst)
        en && (cfg.layout == LAY_PADDED) |-> ({1'b0, addr} < tile_words + (tile_words >> cfg.wlog)));

endmodule

// File: rtl/tile_addr_seq.sv
module tile_addr_seq
    import tas_pkg::*;
#(
    parameter int MAX_LOG2  = 6,
    parameter int SWZ_BASE  = 2,
    parameter int SWZ_SHIFT = 3,
    localparam int IDX_W    = MAX_LOG2,
    localparam int ADDR_W   = $clog2((1 << MAX_LOG2) * ((1 << MAX_LOG2) + 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        width_log2,
    input  logic [2:0]        height_log2,
    input  logic              order_sel,
    input  logic [1:0]        layout_sel,
    input  logic [1:0]        atom_sel,
    input  logic              ready,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    tile_cfg_t        cfg_in, cfg_q;
    logic             busy, last;
    logic [IDX_W-1:0] row, col;

    always_comb begin
        cfg_in.wlog   = width_log2;
        cfg_in.hlog   = height_log2;
        cfg_in.order  = order_e'(order_sel);
        cfg_in.layout = layout_e'(layout_sel);
        cfg_in.atom   = atom_sel;
    end

    tas_walker #(.MAX_LOG2(MAX_LOG2)) u_walker (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ready  (ready),
        .cfg_in (cfg_in),
        .busy   (busy),
        .cfg_q  (cfg_q),
        .row    (row),
        .col    (col),
        .last   (last)
    );

    tas_mapper #(
        .MAX_LOG2  (MAX_LOG2),
        .SWZ_BASE  (SWZ_BASE),
        .SWZ_SHIFT (SWZ_SHIFT)
    ) u_mapper (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .cfg  (cfg_q),
        .row  (row),
        .col  (col),
        .addr (addr)
    );

    assign addr_valid = busy;
    assign done       = busy && last;

    // R6: done only accompanies a presented address
    p_done_valid_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> addr_valid);

    // R6: stream ends after the last address is taken
    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        done && ready |=> !addr_valid);

    // R2: an idle start opens the stream next cycle
    p_open_r2: assert property (@(posedge clk) disable iff (rst)
        !addr_valid && start |=> addr_valid);

endmodule

// File: tb/tile_addr_seq_bench.sv
module tile_addr_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  width_log2 = '0;
    logic [2:0]  height_log2 = '0;
    logic        order_sel = 1'b0;
    logic [1:0]  layout_sel = '0;
    logic [1:0]  atom_sel = '0;
    logic        ready = 1'b0;
    logic        addr_valid;
    logic [12:0] addr;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_addr_seq u_tile_addr_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .width_log2  (width_log2),
        .height_log2 (height_log2),
        .order_sel   (order_sel),
        .layout_sel  (layout_sel),
        .atom_sel    (atom_sel),
        .ready       (ready),
        .addr_valid  (addr_valid),
        .addr        (addr),
        .done        (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_addr(int lay, int at, int wl, int r, int c);
        int w = 1 << wl;
        int a;
        case (lay)
            0: return r * w + c;
            1: return r * (w + 1) + c;
            2: return r * w + (c ^ (r & (w - 1)));
            default: begin
                a = r * w + c;
                return a ^ (((a >> 5) & ((1 << at) - 1)) << 2);
            end
        endcase
    endfunction

    function automatic string lay_tag(int lay);
        case (lay)
            0: return "R8 linear";
            1: return "R9 padded";
            2: return "R10 xor";
            default: return "R11 swizzle";
        endcase
    endfunction

    task automatic run_tile(int o, int lay, int at, int wl_in, int hl_in, int stall_pct, bit poke);
        int wl = (wl_in > 6) ? 6 : wl_in;
        int hl = (hl_in > 6) ? 6 : hl_in;
        int w = 1 << wl;
        int h = 1 << hl;
        int total = w * h;
        int k = 0;
        int r, c, ea;
        bit poked = 0;
        string ot = (o == 0) ? "R3 row-major" : "R4 col-major";
        @(negedge clk);
        width_log2  = 3'(wl_in);
        height_log2 = 3'(hl_in);
        order_sel   = 1'(o);
        layout_sel  = 2'(lay);
        atom_sel    = 2'(at);
        start       = 1'b1;
        ready       = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(addr_valid == 1'b1, "R2 valid after start", int'(addr_valid), 1);
        while (k < total) begin
            ready = (($urandom % 100) >= stall_pct);
            if (poke && !poked && k == 2) begin
                poked       = 1;
                start       = 1'b1;
                layout_sel  = 2'(lay ^ 1);
                order_sel   = 1'(o ^ 1);
                width_log2  = 3'(wl_in ^ 1);
            end
            if (o == 0) begin r = k / w; c = k % w; end
            else        begin r = k % h; c = k / h; end
            ea = exp_addr(lay, at, wl, r, c);
            check(addr_valid == 1'b1, {ot, " R5 R7 R12 valid"}, int'(addr_valid), 1);
            check(int'(addr) == ea, {ot, " ", lay_tag(lay)}, int'(addr), ea);
            check(done == (k == total - 1), "R6 done", int'(done), int'(k == total - 1));
            if (ready && addr_valid) k++;
            @(negedge clk);
            start = 1'b0;
        end
        ready = 1'b0;
        check(addr_valid == 1'b0, "R6 R12 stream ends after W*H", int'(addr_valid), 0);
        check(done == 1'b0, "R6 done low when idle", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state, start during reset is ignored
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(addr_valid == 1'b0, "R1 valid in reset", int'(addr_valid), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst   = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(addr_valid == 1'b0, "R1 idle after reset", int'(addr_valid), 0);

        // directed: 32x32 column walks in every layout
        run_tile(1, 0, 0, 5, 5, 0, 0);
        run_tile(1, 1, 0, 5, 5, 0, 0);
        run_tile(1, 2, 0, 5, 5, 0, 0);
        for (int at = 0; at < 4; at++) run_tile(0, 3, at, 6, 3, 20, 0);
        // full 64x64 tile, and clamped width code 7 (R12)
        run_tile(0, 1, 0, 6, 6, 0, 0);
        run_tile(1, 3, 3, 7, 2, 10, 0);
        run_tile(0, 0, 0, 0, 0, 50, 0);
        // R7: start during a walk with other settings
        run_tile(0, 2, 0, 3, 3, 30, 1);
        run_tile(1, 3, 2, 4, 5, 30, 1);

        for (int i = 0; i < 40; i++) begin
            run_tile(int'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                     int'($urandom % 6), int'($urandom % 6), 30, ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule